// File: doc/BRIEF.md
# Strobe-Qualified SRAM Access Port

This block models one access port of a small on-chip SRAM that is driven by an external strobe, a write-enable level, an address bus and a write-data bus. The port does not use the strobe as a clock. A fast system clock oversamples the strobe and the write enable through a synchronizer, and the block finds their rising and falling edges itself. The address and write data are delayed by the same number of stages, so all inputs stay aligned after synchronization.

A rising strobe edge starts every access. On that edge the block captures the address and takes the cycle type from the level of the write enable. In a read, the addressed word is loaded into the read-data register, and that register then holds it until the next read. In a write, the data is stored at whichever comes first: the write enable falls or the strobe falls. The data stored is the value present at that moment, and it goes to the address captured when the cycle started. The storage is a register array whose depth and width are parameters.

Top module: `strobe_sram_port`

## Requirements
- R1: After reset (rst_n low for at least one clock), rdata_o is 0 and every word of the array reads back as 0.
- R2: The address is taken only on a synchronized rising edge of me_i. Changes on addr_i at any other time do not affect the access.
- R3: If we_i is low when me_i rises, the cycle is a read. rdata_o then becomes the word at the captured address. This holds even if me_i stays high for only one clock period.
- R4: If we_i is high when me_i rises, the cycle is a write. The write ends at the first synchronized falling edge of we_i or of me_i, and the word is stored at that moment.
- R5: Changes on wdata_i during a write are ignored. Only the value present when the write ends is stored.
- R6: A write stores to the address captured at the rising edge that started it, even if addr_i has changed since then.
- R7: A write that ends because we_i falls does not become a read. rdata_o stays unchanged, and no further store happens in that strobe period, even if we_i rises again before me_i falls.
- R8: If we_i and me_i fall in the same clock, exactly one store takes place, and it holds the write data of that moment.
- R9: rdata_o holds its value between reads, including across write cycles to any address.
- R10: A read result appears on rdata_o exactly SYNC_STAGES+1 rising clock edges after the first clock edge at which me_i is seen high. With the default SYNC_STAGES of 2, this is the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| me_i | input | 1 | Access strobe; a rising edge starts a cycle |
| we_i | input | 1 | Write enable; its level at the strobe rise selects read or write, and its fall ends a write |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, held between reads |

## Verification
The embedded assertions check on every cycle the properties that depend only on internal signals. The captured address changes only on a strobe rise. The cycle type follows the write enable at that rise. A write, once open, never produces a read. A store is never followed by a second store in the next clock. rdata_o moves only after a read launch. The directed scenarios show what the assertions cannot: which data value reaches which address, whether the stored value is the one present at the write end, the exact latency through the synchronizer, and the case where both falling edges arrive in the same clock.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

   // Kind of access latched at the strobe rise
   typedef enum logic {
      CYC_READ  = 1'b0,
      CYC_WRITE = 1'b1
   } cyc_kind_e;

   // Edge events for one synchronized control line
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;

endpackage

// File: rtl/stage_pipe.sv
module stage_pipe #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("stage_pipe: WIDTH must be at least 1");
      end
      if (STAGES < 1) begin : g_bad_stages
         $error("stage_pipe: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/edge_ctrl.sv
module edge_ctrl
   import sram_port_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_s,
   input  logic              wen_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] wdata_s,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);

   logic              strobe_prev_q;
   logic              wen_prev_q;
   edge_ev_t          strobe_ev;
   edge_ev_t          wen_ev;
   logic [ADDR_W-1:0] cap_addr_q;
   cyc_kind_e         kind_q;
   logic              wr_open_q;
   logic              wr_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_prev_q <= 1'b0;
         wen_prev_q    <= 1'b0;
      end else begin
         strobe_prev_q <= strobe_s;
         wen_prev_q    <= wen_s;
      end
   end

   always_comb begin
      strobe_ev.rise = strobe_s & ~strobe_prev_q;
      strobe_ev.fall = ~strobe_s & strobe_prev_q;
      wen_ev.rise    = wen_s & ~wen_prev_q;
      wen_ev.fall    = ~wen_s & wen_prev_q;
   end

   // Whichever falling edge comes first closes an open write; both at once close it once
   assign wr_end = wr_open_q & (strobe_ev.fall | wen_ev.fall);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_addr_q <= '0;
         kind_q     <= CYC_READ;
         wr_open_q  <= 1'b0;
      end else begin
         if (strobe_ev.rise) begin
            cap_addr_q <= addr_s;
            kind_q     <= wen_s ? CYC_WRITE : CYC_READ;
            wr_open_q  <= wen_s;
         end else if (wr_end) begin
            wr_open_q  <= 1'b0;
         end
      end
   end

   assign rd_en_o   = strobe_ev.rise & ~wen_s;
   assign rd_addr_o = addr_s;
   assign wr_en_o   = wr_end;
   assign wr_addr_o = cap_addr_q;
   assign wr_data_o = wdata_s;

   AST_ADDR_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_ev.rise |=> $stable(cap_addr_q)); // R2
   AST_TYPE_FROM_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_ev.rise |=> (wr_open_q == (kind_q == CYC_WRITE))); // R4
   AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_open_q |-> !rd_en_o); // R7
   AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o); // R8
   AST_STORE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_open_q); // R4

endmodule

// File: rtl/word_array.sv
module word_array #(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (wr_en_i) begin
               mem_q[wr_addr_i] <= wr_data_i;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_en_i) rdata_q <= mem_q[rd_addr_i];
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/strobe_sram_port.sv
module strobe_sram_port #(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              me_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int BUS_W = 2 + ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("strobe_sram_port: ADDR_W must lie in 1..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("strobe_sram_port: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("strobe_sram_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0]  bus_in;
   logic [BUS_W-1:0]  bus_s;
   logic              strobe_s;
   logic              wen_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] wdata_s;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   // Controls and buses share one pipe so they leave it aligned
   assign bus_in = {me_i, we_i, addr_i, wdata_i};
   assign {strobe_s, wen_s, addr_s, wdata_s} = bus_s;

   stage_pipe #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (bus_in),
      .q_o  (bus_s)
   );

   edge_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_s (strobe_s),
      .wen_s    (wen_s),
      .addr_s   (addr_s),
      .wdata_s  (wdata_s),
      .rd_en_o  (rd_en),
      .rd_addr_o(rd_addr),
      .wr_en_o  (wr_en),
      .wr_addr_o(wr_addr),
      .wr_data_o(wr_data)
   );

   word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en_i  (rd_en),
      .rd_addr_i(rd_addr),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .rdata_o  (rdata_o)
   );

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata_o)); // R9
   AST_NO_RW_SAME_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en)); // R7

endmodule

// File: tb/strobe_sram_port_tb_top.sv
module strobe_sram_port_tb_top;

   localparam int AW = 6;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          me = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   strobe_sram_port #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .me_i   (me),
      .we_i   (we),
      .addr_i (addr),
      .wdata_i(wdata),
      .rdata_o(rdata)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Plain write ended by the strobe fall
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; we = 1'b1;
      step(2);
      me = 1'b1;
      step(3);
      me = 1'b0;
      step(2);
      we = 1'b0;
      step(4);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      addr = a; we = 1'b0;
      step(2);
      me = 1'b1;
      step(4);
      check(req, rdata, exp);
      me = 1'b0;
      step(3);
   endtask

   task automatic t_reset;
      check("R1 rdata after reset", rdata, 8'h00);
      do_read(6'd5, 8'h00, "R1 cleared word 5");
      do_read(6'd63, 8'h00, "R1 cleared word 63");
   endtask

   task automatic t_basic;
      do_write(6'd3, 8'hA5);
      do_write(6'd10, 8'h3C);
      do_read(6'd3, 8'hA5, "R4 write then R3 read word 3");
      do_read(6'd10, 8'h3C, "R4 write then R3 read word 10");
   endtask

   task automatic t_latency;
      do_write(6'd7, 8'h5A);
      do_read(6'd0, 8'h00, "R10 prime rdata");
      addr = 6'd7; we = 1'b0;
      step(2);
      me = 1'b1;
      step(2);
      check("R10 not yet after two edges", rdata, 8'h00);
      step(1);
      check("R10 result on third edge", rdata, 8'h5A);
      me = 1'b0;
      step(3);
   endtask

   task automatic t_short_pulse;
      do_write(6'd12, 8'hC3);
      addr = 6'd12; we = 1'b0;
      step(2);
      me = 1'b1;
      step(1);
      me = 1'b0;
      addr = 6'd13;
      step(4);
      check("R3 one-clock strobe read", rdata, 8'hC3);
   endtask

   task automatic t_addr_ignore;
      addr = 6'd20; wdata = 8'h11; we = 1'b1;
      step(2);
      me = 1'b1;
      step(3);
      addr = 6'd21;
      step(3);
      me = 1'b0;
      step(2);
      we = 1'b0;
      addr = 6'd22;
      step(4);
      do_read(6'd20, 8'h11, "R6 stored at captured address");
      do_read(6'd21, 8'h00, "R2 later address unused");
      do_read(6'd22, 8'h00, "R2 address change with strobe low ignored");
   endtask

   task automatic t_data_late;
      addr = 6'd30; wdata = 8'h01; we = 1'b1;
      step(2);
      me = 1'b1;
      step(2);
      wdata = 8'h02;
      step(2);
      wdata = 8'h77;
      step(2);
      we = 1'b0;
      step(2);
      wdata = 8'hEE;
      step(2);
      me = 1'b0;
      step(4);
      do_read(6'd30, 8'h77, "R5 value at write end stored");
   endtask

   task automatic t_we_end_no_read;
      do_write(6'd40, 8'h99);
      do_read(6'd40, 8'h99, "R7 prime rdata");
      addr = 6'd41; wdata = 8'h44; we = 1'b1;
      step(2);
      me = 1'b1;
      step(3);
      we = 1'b0;
      step(4);
      check("R7 write end by we fall is not a read", rdata, 8'h99);
      wdata = 8'h55; we = 1'b1;
      step(3);
      me = 1'b0;
      step(3);
      we = 1'b0;
      step(4);
      check("R9 rdata held across write", rdata, 8'h99);
      do_read(6'd41, 8'h44, "R7 no second store in same strobe");
   endtask

   task automatic t_simul;
      addr = 6'd50; wdata = 8'h10; we = 1'b1;
      step(2);
      me = 1'b1;
      step(3);
      wdata = 8'hBD;
      me = 1'b0; we = 1'b0;
      step(1);
      wdata = 8'h00;
      step(4);
      do_read(6'd50, 8'hBD, "R8 simultaneous falls single store");
   endtask

   task automatic t_hold;
      do_read(6'd3, 8'hA5, "R9 read before writes");
      do_write(6'd3, 8'h5F);
      do_write(6'd4, 8'h66);
      check("R9 rdata unchanged by writes", rdata, 8'hA5);
      do_read(6'd3, 8'h5F, "R9 new value on next read");
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_basic();
      t_latency();
      t_short_pulse();
      t_addr_ignore();
      t_data_late();
      t_we_end_no_read();
      t_simul();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule